// File: doc/BRIEF.md
# Enhanced parallel port host cycle sequencer

This block turns host bus accesses into Enhanced Parallel Port handshakes, following the 1.7 revision of the protocol. The host side selects one of two peripheral registers, the address register or the data register, with a one-bit select input. The select is captured when a read or write begins. A read drives a strobe toward the peripheral and passes the peripheral bus through to the host. A write latches the host byte, places it on the peripheral bus, lowers the write line and then the strobe.

The ready line to the host follows a two-stage synchronised copy of the peripheral's WAIT signal. A configuration byte can enable a zero-wait-state write, in which the host is told it may finish at once. When WAIT drops before the host ends, that short write turns back into an ordinary one. Host strobes are expected to be synchronous to the block clock.

Top module: `epp_host_seq`

## Requirements
- R1: While a host read (`rd_n` low) is active, exactly one strobe is low: `astrb_n` when `reg_sel` was 0 at the start of the cycle, `dstrb_n` when it was 1. `d_oe` is 1 and `d_out` equals `pd_in`.
- R2: During a read, `iochrdy` is low while the synchronised WAIT is low, until WAIT has been seen high once. It is then released for the rest of the cycle. If WAIT is high when the read begins, `iochrdy` never goes low.
- R3: One clock after `rd_n` returns high, both strobes are high and `d_oe` is 0.
- R4: On a host write, the byte on `d_in` is latched and driven on `pd_out`, with `pd_oe` set to 1. `write_n` goes low one clock after `wr_n` falls. The selected strobe goes low exactly one clock after that.
- R5: One clock after `wr_n` returns high, `write_n`, both strobes and `zws_n` are high and `pd_oe` is 0.
- R6: `pd_out` changes only on a clock where `write_n`, `astrb_n` and `dstrb_n` were all high.
- R7: The zero-wait-state write is enabled only when `cfg[5]` is 1 and `cfg[6]` is 0. In that mode, while WAIT is high during the write, `zws_n` is low and `iochrdy` is high.
- R8: If WAIT goes low during a zero-wait-state write, `zws_n` returns high and stays high for the rest of the cycle. `iochrdy` then goes low until WAIT is high again, as in a normal write.
- R9: In a normal write, `iochrdy` follows the R2 rule and `zws_n` stays high.
- R10: After reset, `write_n`, `astrb_n`, `dstrb_n`, `zws_n` and `iochrdy` are high, and `d_oe` and `pd_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| reg_sel | input | 1 | 0 selects the address register, 1 selects the data register |
| cfg | input | 8 | Configuration byte; bits 5 and 6 control the zero-wait-state write |
| d_in | input | 8 | Host write data |
| d_out | output | 8 | Host read data |
| d_oe | output | 1 | Host data bus drive enable |
| iochrdy | output | 1 | Host ready; low stretches the host cycle |
| zws_n | output | 1 | Zero-wait-state indication, active low |
| pd_in | input | 8 | Peripheral bus input |
| pd_out | output | 8 | Peripheral bus output |
| pd_oe | output | 1 | Peripheral bus drive enable |
| write_n | output | 1 | Peripheral write line, active low |
| astrb_n | output | 1 | Address strobe, active low |
| dstrb_n | output | 1 | Data strobe, active low |
| wait_in | input | 1 | Peripheral WAIT, asynchronous |

## Verification
The bench runs reads with WAIT high from the start and checks that ready never drops. A design that pulled ready low unconditionally would hang fast peripherals. It also lowers WAIT again after a release, to catch a design that re-stretches the host cycle. Writes are timed edge by edge, so that a strobe falling together with the write line, or a bus that moves under an active strobe, is reported. The zero-wait-state checks use the blocking combination of configuration bits. They also drop WAIT in mid-cycle, where a design that kept the zero-wait-state output low, or never stretched ready, would let the host finish a write the peripheral has not accepted.

// File: rtl/epp_seq_pkg.sv
package epp_seq_pkg;
  localparam int unsigned ZWS_ON_BIT    = 5;
  localparam int unsigned ZWS_BLOCK_BIT = 6;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_READ    = 2'd1,
    PH_WSETUP  = 2'd2,
    PH_WSTROBE = 2'd3
  } phase_t;

  function automatic logic zws_allowed(input logic [7:0] cfg);
    return cfg[ZWS_ON_BIT] & ~cfg[ZWS_BLOCK_BIT];
  endfunction

  // returns {dstrb_n, astrb_n}
  function automatic logic [1:0] strobe_levels(input logic active, input logic sel);
    return {~(active & sel), ~(active & ~sel)};
  endfunction

  function automatic logic is_write_phase(input phase_t ph);
    return (ph == PH_WSETUP) || (ph == PH_WSTROBE);
  endfunction
endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          reg_sel,
  input  logic [DW-1:0] d_in,
  output phase_t        phase,
  output logic          sel_q,
  output logic [DW-1:0] wr_data
);
  logic host_idle;
  assign host_idle = rd_n & wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      sel_q   <= 1'b0;
      wr_data <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (!wr_n) begin
            wr_data <= d_in;
            sel_q   <= reg_sel;
            phase   <= PH_WSETUP;
          end else if (!rd_n) begin
            sel_q <= reg_sel;
            phase <= PH_READ;
          end
        end
        PH_READ:    if (rd_n) phase <= PH_IDLE;
        PH_WSETUP:  phase <= wr_n ? PH_IDLE : PH_WSTROBE;
        PH_WSTROBE: if (wr_n) phase <= PH_IDLE;
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  AST_CYCLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && host_idle) |=> (phase == PH_IDLE)); // R5
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) != PH_IDLE && phase != PH_IDLE) |-> $stable(sel_q)); // R1
endmodule

// File: rtl/epp_ready_ctl.sv
module epp_ready_ctl
  import epp_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  logic   wait_s,
  input  logic   zws_cfg,
  output logic   iochrdy,
  output logic   zws_n
);
  logic armed, released, fallback;
  logic active, write_cyc, zws_live, pull_low;

  assign active    = (phase != PH_IDLE);
  assign write_cyc = is_write_phase(phase);
  assign zws_live  = write_cyc & armed & ~fallback;
  assign pull_low  = active & ~wait_s & ~released;
  assign iochrdy   = ~pull_low;
  assign zws_n     = ~(zws_live & wait_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      released <= 1'b0;
      fallback <= 1'b0;
    end else if (!active) begin
      armed    <= zws_cfg;
      released <= 1'b0;
      fallback <= 1'b0;
    end else if (zws_live) begin
      if (!wait_s) fallback <= 1'b1;
    end else if (wait_s) begin
      released <= 1'b1;
    end
  end

  AST_ZWS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !zws_n |-> iochrdy); // R7
  AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $rose(iochrdy)) |-> wait_s); // R2
  AST_FALLBACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback && write_cyc) |-> zws_n); // R8
  AST_ZWS_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !zws_n |-> write_cyc); // R9
endmodule

// File: rtl/epp_host_seq.sv
module epp_host_seq
  import epp_seq_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          reg_sel,
  input  logic [7:0]    cfg,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic          iochrdy,
  output logic          zws_n,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          write_n,
  output logic          astrb_n,
  output logic          dstrb_n,
  input  logic          wait_in
);
  phase_t     phase;
  logic       sel_q, wait_s, strobe_on, quiet;
  logic [1:0] strb;

  epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wait_in), .sync_out(wait_s));

  epp_cycle_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .reg_sel(reg_sel),
    .d_in(d_in), .phase(phase), .sel_q(sel_q), .wr_data(pd_out));

  epp_ready_ctl u_rdy (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wait_s(wait_s),
    .zws_cfg(zws_allowed(cfg)), .iochrdy(iochrdy), .zws_n(zws_n));

  assign strobe_on = (phase == PH_READ) || (phase == PH_WSTROBE);
  assign strb      = strobe_levels(strobe_on, sel_q);
  assign astrb_n   = strb[0];
  assign dstrb_n   = strb[1];
  assign write_n   = ~is_write_phase(phase);
  assign pd_oe     = is_write_phase(phase);
  assign d_oe      = (phase == PH_READ);
  assign d_out     = pd_in;
  assign quiet     = write_n & astrb_n & dstrb_n;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!astrb_n && !dstrb_n)); // R1
  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(astrb_n) || $fell(dstrb_n)) && !write_n) |-> !$past(write_n)); // R4
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_out) |-> $past(quiet)); // R6
  AST_DOE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (write_n && !(astrb_n && dstrb_n))); // R3
endmodule

// File: tb/tb_epp_host_seq.sv
module tb_epp_host_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1, reg_sel = 1'b0, wait_in = 1'b0;
  logic [7:0] cfg = 8'h00, d_in = 8'h00, pd_in = 8'h00;
  logic [7:0] d_out, pd_out;
  logic d_oe, iochrdy, zws_n, pd_oe, write_n, astrb_n, dstrb_n;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic sel; logic is_wr; logic [7:0] pd; } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  epp_host_seq dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .reg_sel(reg_sel),
    .cfg(cfg), .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .iochrdy(iochrdy),
    .zws_n(zws_n), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .write_n(write_n), .astrb_n(astrb_n), .dstrb_n(dstrb_n), .wait_in(wait_in));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: on each strobe fall pop an expected item; watch PD stability (R6)
  logic pa = 1'b1, pdd = 1'b1, pw = 1'b1;
  logic [7:0] ppd = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pd_out !== ppd) chk("R6", {7'b0, pa & pdd & pw}, 8'h01, "pd changed while not quiet");
      if ((pa && !astrb_n) || (pdd && !dstrb_n)) begin
        if (expq.size() == 0) chk("R1", 8'h00, 8'h01, "unexpected strobe");
        else begin
          exp_t e;
          e = expq.pop_front();
          chk("R1", {7'b0, !dstrb_n}, {7'b0, e.sel}, "strobe selected");
          chk("R4", {7'b0, write_n}, {7'b0, !e.is_wr}, "write_n at strobe");
          if (e.is_wr) chk("R4", pd_out, e.pd, "pd at strobe");
        end
      end
    end
    pa = astrb_n; pdd = dstrb_n; pw = write_n; ppd = pd_out;
  end

  task automatic set_wait(input logic v);
    wait_in = v;
    cyc(4);
  endtask

  task automatic do_read(input logic sel, input logic [7:0] pv, input logic w0);
    exp_t e;
    set_wait(w0);
    e.sel = sel; e.is_wr = 0; e.pd = 8'h00; expq.push_back(e);
    pd_in = pv; reg_sel = sel; rd_n = 0;
    cyc(1); reg_sel = ~sel;
    cyc(3);
    chk("R1", {7'b0, d_oe}, 8'h01, "d_oe in read");
    chk("R1", d_out, pv, "read data");
    chk("R2", {7'b0, iochrdy}, {7'b0, w0}, "ready at start");
    if (!w0) begin
      set_wait(1);
      chk("R2", {7'b0, iochrdy}, 8'h01, "ready released");
      set_wait(0);
      chk("R2", {7'b0, iochrdy}, 8'h01, "ready stays released");
    end
    rd_n = 1;
    cyc(1);
    chk("R3", {6'b0, astrb_n, dstrb_n}, 8'h03, "strobes after read");
    chk("R3", {7'b0, d_oe}, 8'h00, "d_oe after read");
  endtask

  task automatic do_write(input logic sel, input logic [7:0] dv, input logic [7:0] c, input logic w0, input logic drop);
    exp_t e;
    logic z;
    z = c[5] & ~c[6];
    cfg = c;
    set_wait(w0);
    e.sel = sel; e.is_wr = 1; e.pd = dv; expq.push_back(e);
    d_in = dv; reg_sel = sel; wr_n = 0;
    cyc(1); d_in = ~dv;
    chk("R4", {6'b0, write_n, sel ? dstrb_n : astrb_n}, 8'h01, "write low, strobe high");
    cyc(1);
    chk("R4", {6'b0, write_n, sel ? dstrb_n : astrb_n}, 8'h00, "write and strobe low");
    chk("R4", pd_out, dv, "latched byte");
    chk("R4", {7'b0, pd_oe}, 8'h01, "pd_oe in write");
    cyc(2);
    if (z && w0) begin
      chk("R7", {6'b0, zws_n, iochrdy}, 8'h01, "zws low, ready high");
      if (drop) begin
        set_wait(0);
        chk("R8", {6'b0, zws_n, iochrdy}, 8'h02, "fallback stretches");
        set_wait(1);
        chk("R8", {6'b0, zws_n, iochrdy}, 8'h03, "fallback released");
      end
    end else begin
      chk("R9", {6'b0, zws_n, iochrdy}, {6'b0, 1'b1, w0}, "normal write ready");
      if (!w0) begin
        set_wait(1);
        chk("R9", {6'b0, zws_n, iochrdy}, 8'h03, "normal write released");
      end
    end
    wr_n = 1;
    cyc(1);
    chk("R5", {4'b0, write_n, astrb_n, dstrb_n, zws_n}, 8'h0F, "lines after write");
    chk("R5", {7'b0, pd_oe}, 8'h00, "pd_oe after write");
  endtask

  initial begin
    cyc(3);
    chk("R10", {1'b0, write_n, astrb_n, dstrb_n, zws_n, iochrdy, d_oe, pd_oe}, 8'h7C, "reset outputs");
    rst_n = 1;
    cyc(2);
    chk("R10", {1'b0, write_n, astrb_n, dstrb_n, zws_n, iochrdy, d_oe, pd_oe}, 8'h7C, "idle outputs");
    do_read(0, 8'hA5, 1);
    do_read(1, 8'h3C, 0);
    do_read(0, 8'h00, 0);
    do_write(0, 8'h5A, 8'h00, 0, 0);
    do_write(1, 8'hC3, 8'h00, 1, 0);
    do_write(1, 8'h81, 8'h20, 1, 0);
    do_write(0, 8'h7E, 8'h20, 1, 1);
    do_write(1, 8'h19, 8'h60, 1, 0);
    do_write(0, 8'hE4, 8'h20, 0, 0);
    cyc(3);
    chk("R1", expq.size(), 8'h00, "all strobes seen");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule